// File: doc/BRIEF.md
# Banked Address Translation Unit

This block sits between the address sources of a processor subsystem and the external memory bus. It takes a 24-bit logical address, either from the CPU or from the display controller's DMA engine, and produces the 24-bit physical address that goes to the external pins. It also drives one active-low chip select for each local window.

Two 2 MB local windows are defined by the top three address bits: the Y window at 400000H and the Z window at 800000H. Each window owns four bank registers, one for each access kind: instruction fetch, data read, data write and display DMA read. The register that matches the current access supplies the bank. When that register is enabled, the window offset is kept and the upper bits are replaced by the bank number. Otherwise the address passes through untouched.

Software programs the registers through a single write port. A write to a window's fetch register is refused while code is running from that same window. Chip selects are decoded from the logical address, so they do not depend on how the address was translated.

Top module: `bank_xlat`

## Requirements
- R1: After a synchronous reset with `rst_n` low, every bank register is disabled, and every access leaves `phys_addr` equal to the selected logical address.
- R2: When the selected register is enabled and the logical address is in a window, `phys_addr` = bank × 200000H + (logical address mod 200000H). The offset bits [20:0] always pass through unchanged.
- R3: For CPU accesses, `cpu_kind` selects the register: 0 = fetch, 1 = data read, 2 = data write, 3 = treated as data read. Each kind uses only its own register.
- R4: When `dma_active` is 1, the logical address is `dma_addr` and the display register (`reg_kind` 3) of its window is used. `cpu_addr` and `cpu_kind` are then ignored.
- R5: An address whose bits [23:21] are neither 010b (Y) nor 100b (Z), or an address that hits a window whose selected register has its enable bit clear, gives `phys_addr` equal to the logical address.
- R6: `cs_y_n` is low exactly when the logical address bits [23:21] equal 010b, and `cs_z_n` is low exactly when they equal 100b. The decode does not depend on the register contents.
- R7: A register write with `reg_kind` 0 (fetch) to window `reg_win` (0 = Y, 1 = Z) is ignored while `exec_addr` lies in that same window. Writes to other kinds, and writes to the other window, still take effect.
- R8: A register write is captured on the rising clock edge where `reg_we` is 1. Before that edge, the translation uses the old value.
- R9: In `reg_wdata`, bit 15 is the enable bit and bits [2:0] are the bank number. All other bits are ignored; for example, FFF9H selects bank 1 with translation enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Bank register write strobe |
| reg_win | input | 1 | Target window: 0 = Y, 1 = Z |
| reg_kind | input | 2 | Target register: 0 fetch, 1 read, 2 write, 3 display DMA |
| reg_wdata | input | 16 | Register value: bit 15 enable, bits [2:0] bank |
| exec_addr | input | 24 | Logical address of the instruction now executing |
| cpu_addr | input | 24 | CPU logical address |
| cpu_kind | input | 2 | CPU access kind |
| dma_active | input | 1 | Display DMA owns the current cycle |
| dma_addr | input | 24 | Display DMA logical address |
| phys_addr | output | 24 | Translated external address |
| cs_y_n | output | 1 | Active-low select for the Y window |
| cs_z_n | output | 1 | Active-low select for the Z window |

## Verification
The in-line assertions check, on every cycle, the following properties:
- the window offset always reaches the output;
- the two chip selects are never low together;
- an address outside both windows is never altered;
- a refused fetch-register write leaves that register unchanged.

The bench scenarios are needed for the rest:
- that each access kind picks its own register, and that DMA picks the display register;
- that the bank arithmetic is right for every bank value;
- that a write becomes visible only after its clock edge;
- that the enable bit and the ignored data bits behave as stated.

// File: rtl/bank_xlat.sv
module bank_xlat #(
  parameter int AW       = 24,
  parameter int WIN_BITS = 21,
  parameter int REG_W    = 16,
  parameter int EN_BIT   = 15,
  parameter int Y_TAG    = 2,
  parameter int Z_TAG    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic             reg_win,
  input  logic [1:0]       reg_kind,
  input  logic [REG_W-1:0] reg_wdata,
  input  logic [AW-1:0]    exec_addr,
  input  logic [AW-1:0]    cpu_addr,
  input  logic [1:0]       cpu_kind,
  input  logic             dma_active,
  input  logic [AW-1:0]    dma_addr,
  output logic [AW-1:0]    phys_addr,
  output logic             cs_y_n,
  output logic             cs_z_n
);
  localparam int BW = AW - WIN_BITS;
  localparam logic [1:0] K_FETCH = 2'd0;
  localparam logic [1:0] K_READ  = 2'd1;
  localparam logic [1:0] K_LCD   = 2'd3;

  logic          en_q   [2][4];
  logic [BW-1:0] bank_q [2][4];

  logic [AW-1:0] sel_addr;
  logic [1:0]    sel_kind;
  logic          in_y, in_z, hit, exec_y, exec_z, fetch_locked;

  assign sel_addr = dma_active ? dma_addr : cpu_addr;
  assign sel_kind = dma_active ? K_LCD : ((cpu_kind == 2'd3) ? K_READ : cpu_kind);

  assign in_y = sel_addr[AW-1:WIN_BITS] == BW'(Y_TAG);
  assign in_z = sel_addr[AW-1:WIN_BITS] == BW'(Z_TAG);
  assign hit  = (in_y | in_z) & en_q[in_z][sel_kind];

  assign phys_addr = hit ? {bank_q[in_z][sel_kind], sel_addr[WIN_BITS-1:0]} : sel_addr;
  assign cs_y_n    = ~in_y;
  assign cs_z_n    = ~in_z;

  assign exec_y = exec_addr[AW-1:WIN_BITS] == BW'(Y_TAG);
  assign exec_z = exec_addr[AW-1:WIN_BITS] == BW'(Z_TAG);
  assign fetch_locked = (reg_kind == K_FETCH) & (reg_win ? exec_z : exec_y);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int w = 0; w < 2; w++)
        for (int k = 0; k < 4; k++) begin
          en_q[w][k]   <= 1'b0;
          bank_q[w][k] <= '0;
        end
    end else if (reg_we && !fetch_locked) begin
      en_q[reg_win][reg_kind]   <= reg_wdata[EN_BIT];
      bank_q[reg_win][reg_kind] <= reg_wdata[BW-1:0];
    end
  end

  assert_offset_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    phys_addr[WIN_BITS-1:0] == (dma_active ? dma_addr[WIN_BITS-1:0] : cpu_addr[WIN_BITS-1:0]));

  assert_outside_untouched_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_y_n && cs_z_n) |-> phys_addr == (dma_active ? dma_addr : cpu_addr));

  assert_cs_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(!cs_y_n && !cs_z_n));

  assert_fetch_lock_y_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && !reg_win && reg_kind == K_FETCH && exec_y)
      |=> ($stable(bank_q[0][0]) && $stable(en_q[0][0])));

  assert_fetch_lock_z_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_win && reg_kind == K_FETCH && exec_z)
      |=> ($stable(bank_q[1][0]) && $stable(en_q[1][0])));
endmodule

// File: tb/tb_bank_xlat.sv
module tb_bank_xlat;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic        reg_we = 0, reg_win = 0;
  logic [1:0]  reg_kind = 0;
  logic [15:0] reg_wdata = 0;
  logic [23:0] exec_addr = 0, cpu_addr = 0, dma_addr = 0;
  logic [1:0]  cpu_kind = 0;
  logic        dma_active = 0;
  logic [23:0] phys_addr;
  logic        cs_y_n, cs_z_n;

  int checks = 0, failures = 0, cycles = 0;
  logic       m_en [2][4];
  logic [2:0] m_bk [2][4];

  bank_xlat dut (.clk, .rst_n, .reg_we, .reg_win, .reg_kind, .reg_wdata, .exec_addr,
                 .cpu_addr, .cpu_kind, .dma_active, .dma_addr, .phys_addr, .cs_y_n, .cs_z_n);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      failures++;
      $display("FAIL watchdog: actual=%0d cycles expected<=100000", cycles);
      summary();
    end
  end

  function automatic logic [23:0] model(logic [23:0] a, int k);
    int w;
    if (a[23:21] == 3'd2) w = 0;
    else if (a[23:21] == 3'd4) w = 1;
    else return a;
    if (!m_en[w][k]) return a;
    return {m_bk[w][k], a[20:0]};
  endfunction

  task automatic wr(int w, int k, logic [15:0] d);
    @(negedge clk);
    reg_we = 1; reg_win = w[0]; reg_kind = k[1:0]; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
    if (!(k == 0 && exec_addr[23:21] == (w == 0 ? 3'd2 : 3'd4))) begin
      m_en[w][k] = d[15];
      m_bk[w][k] = d[2:0];
    end
  endtask

  task automatic expect_val(string rq, logic [23:0] act, logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%06h expected=%06h", rq, act, exp);
    end
  endtask

  // code: 0..3 cpu_kind, 4 = display DMA
  task automatic acc(string rq, logic [23:0] a, int code);
    int k;
    if (code == 4) begin
      dma_active = 1; dma_addr = a; cpu_addr = ~a; cpu_kind = 2'd2; k = 3;
    end else begin
      dma_active = 0; cpu_addr = a; dma_addr = ~a; cpu_kind = code[1:0];
      k = (code == 3) ? 1 : code;
    end
    #1;
    expect_val(rq, phys_addr, model(a, k));
    expect_val({rq, " cs"}, {22'd0, cs_y_n, cs_z_n},
               {22'd0, a[23:21] != 3'd2, a[23:21] != 3'd4});
  endtask

  initial begin
    for (int w = 0; w < 2; w++)
      for (int k = 0; k < 4; k++) begin m_en[w][k] = 0; m_bk[w][k] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: after reset, every access passes through
    for (int t = 0; t < 8; t++)
      for (int c = 0; c < 5; c++)
        acc("R1", {t[2:0], 21'h0ABCDE}, c);

    // R2 R3 R4 R6: sweep all banks with distinct banks per register
    for (int b = 0; b < 8; b++) begin
      for (int w = 0; w < 2; w++)
        for (int k = 0; k < 4; k++)
          wr(w, k, 16'h8000 | 16'((b + w*4 + k) % 8));
      for (int w = 0; w < 2; w++)
        for (int c = 0; c < 5; c++) begin
          logic [2:0] tg;
          tg = (w == 0) ? 3'd2 : 3'd4;
          acc("R2", {tg, 21'h000000}, c);
          acc("R2", {tg, 21'h1FFFFF}, c);
          acc(c == 4 ? "R4" : "R3", {tg, 21'h1000AB}, c);
          acc("R6", {tg, 21'h055055}, c);
        end
    end

    // R5: outside tags are left alone even with all registers enabled
    for (int t = 0; t < 8; t++)
      if (t != 2 && t != 4)
        for (int c = 0; c < 5; c++) acc("R5", {t[2:0], 21'h123456}, c);

    // Worked mappings
    wr(0, 2, 16'h8001);
    acc("R2", 24'h400000, 2);
    expect_val("R2 Y bank1", phys_addr, 24'h200000);
    wr(0, 1, 16'h8000);
    acc("R2", 24'h5000AB, 1);
    expect_val("R2 Y bank0", phys_addr, 24'h1000AB);
    wr(1, 1, 16'h8000);
    acc("R2", 24'h800000, 1);
    expect_val("R2 Z bank0", phys_addr, 24'h000000);
    expect_val("R6 Z cs", {22'd0, cs_y_n, cs_z_n}, 24'd2);
    wr(0, 3, 16'h8001);
    acc("R4", 24'h400000, 4);
    expect_val("R4 dma bank1", phys_addr, 24'h200000);

    // R5: enable bit clear disables translation
    wr(0, 1, 16'h0003);
    acc("R5", 24'h412345, 1);
    expect_val("R5 disabled", phys_addr, 24'h412345);

    // R9: unused bits ignored
    wr(0, 2, 16'hFFF9);
    acc("R9", 24'h400000, 2);
    expect_val("R9 FFF9", phys_addr, 24'h200000);

    // R8: old value until the capturing edge
    wr(1, 2, 16'h8003);
    @(negedge clk);
    reg_we = 1; reg_win = 1; reg_kind = 2'd2; reg_wdata = 16'h8006;
    acc("R8", 24'h900010, 2);
    expect_val("R8 before edge", phys_addr, 24'h700010);
    @(negedge clk);
    reg_we = 0;
    m_bk[1][2] = 3'd6;
    acc("R8", 24'h900010, 2);
    expect_val("R8 after edge", phys_addr, 24'hD00010);

    // R7: fetch register lock while executing in the same window
    wr(0, 0, 16'h8002);
    exec_addr = 24'h400100;
    wr(0, 0, 16'h8005);
    acc("R7", 24'h400000, 0);
    expect_val("R7 Y fetch locked", phys_addr, 24'h400000 | 24'h000000 | {3'd2, 21'd0});
    wr(1, 0, 16'h8006);
    acc("R7", 24'h800000, 0);
    expect_val("R7 Z fetch taken", phys_addr, 24'hC00000);
    wr(0, 1, 16'h8007);
    acc("R7", 24'h400000, 1);
    expect_val("R7 Y read taken", phys_addr, 24'hE00000);
    exec_addr = 24'h800040;
    wr(1, 0, 16'h8001);
    acc("R7", 24'h800000, 0);
    expect_val("R7 Z fetch locked", phys_addr, 24'hC00000);
    wr(0, 0, 16'h8005);
    acc("R7", 24'h400000, 0);
    expect_val("R7 Y fetch taken", phys_addr, 24'hA00000);

    // R1: reset again restores pass-through
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    for (int w = 0; w < 2; w++)
      for (int k = 0; k < 4; k++) m_en[w][k] = 0;
    for (int c = 0; c < 5; c++) acc("R1", 24'h4ABCDE, c);
    acc("R1", 24'h876543, 4);

    summary();
  end
endmodule